// File: doc/BRIEF.md
# Display mode register interface

This block is the register front end of a linear-framebuffer display controller. A host reaches it through one 4 KiB memory-mapped aperture. The aperture holds a bank of eleven 16-bit mode registers and a small 32-bit extension window. The mode registers carry resolution, colour depth, enable, virtual width and panning offsets. The extension window carries a framebuffer byte-order control and a size word.

From the stored registers the block derives the active display mode on every cycle. The derived mode gives bytes per pixel, width, height, line stride, start offset, total size and a valid flag. Before it flags a mode as valid, the block checks depth, enable, minimum resolution and the fit inside the configured video memory. A scan-out or update engine uses these registered results directly. A one-cycle pulse tells that engine when any derived field has changed.

Top module: `disp_mode_regs`

## Requirements
- R1: After reset, all mode outputs are zero, `mode_valid` and `mode_change` are low, `fb_big_endian` is low (little-endian), and `rd_valid` is low.
- R2: Bank index is (address − 0x500) >> 1. Index 0 (address 0x500) always reads 0x0000B0C5. Index 10 (address 0x514) always reads the configured video memory size divided by 65536. Writes to these two indices change neither readback nor mode.
- R3: A read returns its data on `rdata` with `rd_valid` high in the cycle after `rd_en`. Indices 1..9 (xres, yres, depth, enable, bank, virtual width, virtual height, x offset, y offset) read back the last 16-bit value written, zero-extended.
- R4: A read of bank index 11 or above within page 0x5xx returns 0xFFFFFFFF, and a write there changes no register. Any address outside pages 0x5xx and 0x6xx reads zero.
- R5: In the extension window, address 0x600 reads 8. Address 0x604 reads 0x1E1E1E1E when little-endian and 0xBEBEBEBE when big-endian. Every other offset reads zero.
- R6: A write to 0x604 sets big-endian only with data 0xBEBEBEBE and little-endian only with data 0x1E1E1E1E. Any other data leaves `fb_big_endian` unchanged.
- R7: A mode is valid only if bit 0 of the enable register is set and the depth register holds 16 (2 bytes per pixel) or 32 (4 bytes per pixel).
- R8: Stride equals max(virtual width, xres) times bytes per pixel. Size equals stride times yres.
- R9: Start offset equals x offset times bytes per pixel plus y offset times stride.
- R10: A mode is invalid when xres or yres is below 64, or when offset plus size exceeds the video memory size. An offset plus size exactly equal to the video memory size is allowed. While invalid, every geometry output reads zero.
- R11: Mode outputs take a new value on the clock edge after the edge that writes a register. `mode_change` is high for exactly that one cycle when any derived field differs from its previous value, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 12 | Byte address inside the aperture |
| wdata | input | 32 | Write data (mode bank uses bits 15:0) |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | `rdata` holds the result of the previous cycle's read |
| mode_valid | output | 1 | Derived mode is usable |
| mode_bytepp | output | 3 | Bytes per pixel (2 or 4) |
| mode_width | output | 16 | Visible width in pixels |
| mode_height | output | 16 | Visible height in lines |
| mode_stride | output | 18 | Line stride in bytes |
| mode_offset | output | 36 | Start offset in bytes |
| mode_size | output | 36 | Framebuffer size in bytes |
| mode_change | output | 1 | One-cycle pulse on any derived-field change |
| fb_big_endian | output | 1 | Framebuffer byte order is big-endian |

## Verification
The geometry path is driven with random register writes. The depth values mix the legal 16 and 32 with illegal ones, and the resolutions include some below 64. Virtual widths fall both below and above xres, so the clamp is exercised in both directions. Directed cases place offset plus size exactly at the video memory limit and one pixel beyond it, so an off-by-one in the bound compare cannot hide. Writes that leave the derived mode unchanged separate a correct change pulse from one that fires on every write. Reads of fixed indices, out-of-range indices, the extension window and a non-magic byte-order write separate stored data from fixed or ignored locations.

// File: rtl/disp_mode_pkg.sv
package disp_mode_pkg;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int RW   = 16;
  localparam int NREG = 11;
  localparam int IDXW = 7;
  localparam int STW  = RW + 2;
  localparam int GW   = 2 * RW + 4;

  localparam logic [3:0] BANK_PAGE = 4'h5;
  localparam logic [3:0] EXT_PAGE  = 4'h6;

  localparam int IDX_ID    = 0;
  localparam int IDX_XRES  = 1;
  localparam int IDX_YRES  = 2;
  localparam int IDX_BPP   = 3;
  localparam int IDX_EN    = 4;
  localparam int IDX_BANK  = 5;
  localparam int IDX_VWID  = 6;
  localparam int IDX_VHGT  = 7;
  localparam int IDX_XOFF  = 8;
  localparam int IDX_YOFF  = 9;
  localparam int IDX_VMEM  = 10;

  localparam logic [RW-1:0] ID_WORD   = 16'hB0C5;
  localparam logic [DW-1:0] ORD_LE    = 32'h1E1E1E1E;
  localparam logic [DW-1:0] ORD_BE    = 32'hBEBEBEBE;
  localparam logic [DW-1:0] EXT_BYTES = 32'd8;
  localparam logic [7:0]    EXT_ORD_OFS = 8'h04;

  typedef struct packed {
    logic            valid;
    logic [2:0]      bytepp;
    logic [RW-1:0]   width;
    logic [RW-1:0]   height;
    logic [STW-1:0]  stride;
    logic [GW-1:0]   offset;
    logic [GW-1:0]   size;
  } mode_t;
endpackage

// File: rtl/dm_reg_bank.sv
module dm_reg_bank
  import disp_mode_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [NREG-1:0][RW-1:0]    bank_o,
  output logic                       big_endian_o
);
  logic            in_bank;
  logic [IDXW-1:0] wr_idx;
  logic            ord_hit;
  logic            ord_d, ord_q;

  assign in_bank = wr_en && (addr[AW-1:8] == BANK_PAGE);
  assign wr_idx  = addr[7:1];
  assign ord_hit = wr_en && (addr[AW-1:8] == EXT_PAGE) && (addr[7:0] == EXT_ORD_OFS);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_ID || i == IDX_VMEM) begin : g_fixed
      assign bank_o[i] = '0;
    end else begin : g_store
      logic [RW-1:0] q, d;
      always_comb begin
        d = q;
        if (in_bank && wr_idx == IDXW'(i)) d = wdata[RW-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign bank_o[i] = q;
    end
  end

  always_comb begin
    ord_d = ord_q;
    if (ord_hit && wdata == ORD_BE) ord_d = 1'b1;
    if (ord_hit && wdata == ORD_LE) ord_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ord_q <= 1'b0;
    else        ord_q <= ord_d;
  end

  assign big_endian_o = ord_q;

  // R6
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ord_hit && (wdata == ORD_BE || wdata == ORD_LE)) |=> $stable(big_endian_o));
endmodule

// File: rtl/dm_readback.sv
module dm_readback
  import disp_mode_pkg::*;
#(
  parameter longint unsigned VMEM_BYTES = 64'd16777216
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][RW-1:0]  bank_i,
  input  logic                     big_endian_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     rd_valid_o
);
  localparam logic [RW-1:0] VMEM_UNITS = RW'(VMEM_BYTES / 64'd65536);

  logic [IDXW-1:0] rd_idx;
  logic [DW-1:0]   rd_d, rd_q;
  logic            vld_q;
  logic            oob_rd;

  assign rd_idx = addr[7:1];
  assign oob_rd = rd_en && (addr[AW-1:8] == BANK_PAGE) && (rd_idx >= IDXW'(NREG));

  always_comb begin
    rd_d = '0;
    if (addr[AW-1:8] == BANK_PAGE) begin
      if (rd_idx == IDXW'(IDX_ID))        rd_d = {{(DW-RW){1'b0}}, ID_WORD};
      else if (rd_idx == IDXW'(IDX_VMEM)) rd_d = {{(DW-RW){1'b0}}, VMEM_UNITS};
      else if (rd_idx >= IDXW'(NREG))     rd_d = '1;
      else begin
        for (int i = 0; i < NREG; i++)
          if (rd_idx == IDXW'(i)) rd_d = {{(DW-RW){1'b0}}, bank_i[i]};
      end
    end else if (addr[AW-1:8] == EXT_PAGE) begin
      if (addr[7:0] == 8'h00)             rd_d = EXT_BYTES;
      else if (addr[7:0] == EXT_ORD_OFS)  rd_d = big_endian_i ? ORD_BE : ORD_LE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rdata_o    = rd_q;
  assign rd_valid_o = vld_q;

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid_o);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid_o && $stable(rdata_o)));
  // R4
  oob_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oob_rd |=> (rdata_o == '1));
endmodule

// File: rtl/dm_geometry.sv
module dm_geometry
  import disp_mode_pkg::*;
#(
  parameter longint unsigned VMEM_BYTES = 64'd16777216,
  parameter int              MIN_RES    = 64
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  xres,
  input  logic [RW-1:0]  yres,
  input  logic [RW-1:0]  depth,
  input  logic [RW-1:0]  enable,
  input  logic [RW-1:0]  vwidth,
  input  logic [RW-1:0]  xoff,
  input  logic [RW-1:0]  yoff,
  output mode_t          mode_o,
  output logic           change_o
);
  logic [2:0]     bpp_c;
  logic [RW-1:0]  vw_c;
  logic [STW-1:0] stride_c;
  logic [GW-1:0]  size_c, offset_c;
  logic [63:0]    end_c;
  logic           ok_c;
  mode_t          mode_d, mode_q;
  logic           chg_d, chg_q;

  always_comb begin
    case (depth)
      16'd16:  bpp_c = 3'd2;
      16'd32:  bpp_c = 3'd4;
      default: bpp_c = 3'd0;
    endcase
    vw_c     = (vwidth < xres) ? xres : vwidth;
    stride_c = STW'(vw_c) * STW'(bpp_c);
    size_c   = GW'(stride_c) * GW'(yres);
    offset_c = GW'(xoff) * GW'(bpp_c) + GW'(yoff) * GW'(stride_c);
    end_c    = 64'(offset_c) + 64'(size_c);
    ok_c     = enable[0] && (bpp_c != 3'd0) &&
               (xres >= RW'(MIN_RES)) && (yres >= RW'(MIN_RES)) &&
               (end_c <= VMEM_BYTES);
  end

  always_comb begin
    mode_d = '0;
    if (ok_c) begin
      mode_d.valid  = 1'b1;
      mode_d.bytepp = bpp_c;
      mode_d.width  = xres;
      mode_d.height = yres;
      mode_d.stride = stride_c;
      mode_d.offset = offset_c;
      mode_d.size   = size_c;
    end
    chg_d = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= chg_d;
    end
  end

  assign mode_o   = mode_q;
  assign change_o = chg_q;

  // R7
  valid_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.valid |-> (mode_q.bytepp == 3'd2 || mode_q.bytepp == 3'd4));
  // R10
  valid_min_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.valid |-> (mode_q.width >= RW'(MIN_RES) && mode_q.height >= RW'(MIN_RES)));
  // R10
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.valid |-> (mode_q.stride == '0 && mode_q.size == '0 && mode_q.offset == '0));
  // R8
  stride_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.valid |-> (32'(mode_q.stride) >= 32'(mode_q.width) * 32'(mode_q.bytepp)));
  // R11
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |-> (mode_q != $past(mode_q)));
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
  import disp_mode_pkg::*;
#(
  parameter longint unsigned VMEM_BYTES = 64'd16777216,
  parameter int              MIN_RES    = 64
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [11:0]    addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           rd_valid,
  output logic           mode_valid,
  output logic [2:0]     mode_bytepp,
  output logic [15:0]    mode_width,
  output logic [15:0]    mode_height,
  output logic [17:0]    mode_stride,
  output logic [35:0]    mode_offset,
  output logic [35:0]    mode_size,
  output logic           mode_change,
  output logic           fb_big_endian
);
  logic [NREG-1:0][RW-1:0] bank;
  logic                    big_end;
  mode_t                   mode;

  dm_reg_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .bank_o       (bank),
    .big_endian_o (big_end)
  );

  dm_readback #(.VMEM_BYTES(VMEM_BYTES)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .addr         (addr),
    .bank_i       (bank),
    .big_endian_i (big_end),
    .rdata_o      (rdata),
    .rd_valid_o   (rd_valid)
  );

  dm_geometry #(.VMEM_BYTES(VMEM_BYTES), .MIN_RES(MIN_RES)) u_geo (
    .clk      (clk),
    .rst_n    (rst_n),
    .xres     (bank[IDX_XRES]),
    .yres     (bank[IDX_YRES]),
    .depth    (bank[IDX_BPP]),
    .enable   (bank[IDX_EN]),
    .vwidth   (bank[IDX_VWID]),
    .xoff     (bank[IDX_XOFF]),
    .yoff     (bank[IDX_YOFF]),
    .mode_o   (mode),
    .change_o (mode_change)
  );

  assign mode_valid    = mode.valid;
  assign mode_bytepp   = mode.bytepp;
  assign mode_width    = mode.width;
  assign mode_height   = mode.height;
  assign mode_stride   = mode.stride;
  assign mode_offset   = mode.offset;
  assign mode_size     = mode.size;
  assign fb_big_endian = big_end;
endmodule

// File: tb/test_disp_mode_regs.sv
`timescale 1ns/1ps
module test_disp_mode_regs;
  localparam longint unsigned VMEM = 64'd16777216;

  typedef struct packed {
    logic        v;
    logic [2:0]  b;
    logic [15:0] w, h;
    logic [63:0] st, off, sz;
  } geo_t;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        rd_valid, mode_valid, mode_change, fb_big_endian;
  logic [2:0]  mode_bytepp;
  logic [15:0] mode_width, mode_height;
  logic [17:0] mode_stride;
  logic [35:0] mode_offset, mode_size;

  int   n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [15:0] sh [0:10];
  geo_t prev_geo;

  always #2 clk = ~clk;

  disp_mode_regs #(.VMEM_BYTES(VMEM)) i_disp_mode_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .mode_valid(mode_valid),
    .mode_bytepp(mode_bytepp), .mode_width(mode_width), .mode_height(mode_height),
    .mode_stride(mode_stride), .mode_offset(mode_offset), .mode_size(mode_size),
    .mode_change(mode_change), .fb_big_endian(fb_big_endian));

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic geo_t model();
    geo_t g;
    longint unsigned b, vw, st, sz, off;
    g = '0;
    b = (sh[3] == 16'd16) ? 2 : (sh[3] == 16'd32) ? 4 : 0;
    vw = (sh[6] < sh[1]) ? sh[1] : sh[6];
    st = vw * b;
    sz = st * sh[2];
    off = sh[8] * b + sh[9] * st;
    if (sh[4][0] && b != 0 && sh[1] >= 64 && sh[2] >= 64 && off + sz <= VMEM) begin
      g.v = 1'b1; g.b = 3'(b); g.w = sh[1]; g.h = sh[2];
      g.st = st; g.off = off; g.sz = sz;
    end
    return g;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    chk("R3 rd_valid", rd_valid, 1);
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_geo(geo_t e, logic exp_chg);
    chk(e.v ? "R7 valid" : "R10 valid", mode_valid, e.v);
    chk("R7 bytepp", mode_bytepp, e.b);
    chk("R10 width", mode_width, e.w);
    chk("R10 height", mode_height, e.h);
    chk("R8 stride", mode_stride, e.st);
    chk("R8 size", mode_size, e.sz);
    chk("R9 offset", mode_offset, e.off);
    chk("R11 mode_change", mode_change, exp_chg);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    geo_t e;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a[11:8] == 4'h5 && a[7:1] >= 1 && a[7:1] <= 9) sh[a[7:1]] = d[15:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    e = model();
    check_geo(e, e != prev_geo);
    prev_geo = e;
  endtask

  task automatic wreg(input int idx, input logic [15:0] v);
    wr(12'h500 + 12'(idx * 2), {16'h0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] v;
    int idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i <= 10; i++) sh[i] = '0;
    prev_geo = '0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid", mode_valid, 0);
    chk("R1 size", mode_size, 0);
    chk("R1 stride", mode_stride, 0);
    chk("R1 change", mode_change, 0);
    chk("R1 endian", fb_big_endian, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // R2 fixed readbacks
    rd(12'h500, d); chk("R2 id", d, 32'h0000B0C5);
    rd(12'h514, d); chk("R2 vmem", d, VMEM / 65536);
    wr(12'h500, 32'h1234); wr(12'h514, 32'h7);
    rd(12'h500, d); chk("R2 id after write", d, 32'h0000B0C5);
    rd(12'h514, d); chk("R2 vmem after write", d, VMEM / 65536);

    // R4 out-of-range and unmapped
    rd(12'h516, d); chk("R4 oob 11", d, 32'hFFFFFFFF);
    rd(12'h5FE, d); chk("R4 oob top", d, 32'hFFFFFFFF);
    wr(12'h516, 32'h0040); wr(12'h520, 32'h0020);
    rd(12'h700, d); chk("R4 unmapped", d, 0);
    rd(12'h000, d); chk("R4 unmapped low", d, 0);

    // R5 extension window
    rd(12'h600, d); chk("R5 size", d, 8);
    rd(12'h604, d); chk("R5 order le", d, 32'h1E1E1E1E);
    rd(12'h608, d); chk("R5 other", d, 0);
    rd(12'h602, d); chk("R5 unaligned", d, 0);

    // R6 byte order
    wr(12'h604, 32'h12345678); chk("R6 non-magic", fb_big_endian, 0);
    wr(12'h604, 32'hBEBEBEBE); chk("R6 to big", fb_big_endian, 1);
    rd(12'h604, d); chk("R5 order be", d, 32'hBEBEBEBE);
    wr(12'h604, 32'h0); chk("R6 ignored", fb_big_endian, 1);
    wr(12'h600, 32'h1E1E1E1E); chk("R6 wrong offset", fb_big_endian, 1);
    wr(12'h604, 32'h1E1E1E1E); chk("R6 to little", fb_big_endian, 0);

    // Directed geometry: bound exactly at video memory
    wreg(1, 16'd1024); wreg(2, 16'd1024); wreg(3, 16'd32);
    wreg(9, 16'd3072); wreg(4, 16'd1);
    chk("R10 exact fit valid", mode_valid, 1);
    @(posedge clk); #1;
    chk("R11 pulse drops", mode_change, 0);
    wreg(8, 16'd1);
    chk("R10 one past limit", mode_valid, 0);
    wreg(8, 16'd0); wreg(9, 16'd0);
    wreg(5, 16'hABCD);
    chk("R11 no change on bank write", mode_change, 0);
    wreg(1, 16'd63);
    chk("R10 width 63", mode_valid, 0);
    wreg(1, 16'd64);
    chk("R10 width 64", mode_valid, 1);
    wreg(3, 16'd24);
    chk("R7 depth 24", mode_valid, 0);
    wreg(3, 16'd16);
    chk("R7 depth 16 bpp", mode_bytepp, 2);
    wreg(6, 16'd2000);
    chk("R8 virt width clamp", mode_stride, 4000);
    wreg(4, 16'd2);
    chk("R7 enable bit0", mode_valid, 0);
    wreg(4, 16'd3);

    // Random register traffic
    for (int it = 0; it < 300; it++) begin
      idx = 1 + int'($urandom % 9);
      case (idx)
        1, 2: v = ($urandom % 8 == 0) ? 16'($urandom % 80) : 16'(64 + $urandom % 1200);
        3: begin
          case ($urandom % 6)
            0, 1: v = 16'd16;
            2, 3: v = 16'd32;
            4: v = 16'd8;
            default: v = 16'd24;
          endcase
        end
        4: v = 16'($urandom % 4);
        6: v = 16'($urandom % 1500);
        8: v = 16'($urandom % 256);
        9: v = 16'($urandom % 2048);
        default: v = 16'($urandom);
      endcase
      wreg(idx, v);
    end

    // R3 readback of stored registers
    for (int i = 1; i <= 9; i++) begin
      rd(12'h500 + 12'(i * 2), d);
      chk("R3 stored readback", d, {16'h0, sh[i]});
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule